// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencer

This block sequences power for one downstream hot-plug slot of a PCI Express switch port. It chooses the card-present indication from either a dedicated presence pin or a serial receiver-detect result, as a configuration bit selects. On a power-on command with a card present, it enables slot power. After a selectable delay it reports power valid, and after a second selectable delay it releases the active-low slot reset.

On a power-off command from the running state, the block can first raise a turn-off message request and hold power until an acknowledge comes back. A watchdog forces the power-down if no acknowledge arrives. Removing the card from any powered state drops reset and power at once. A power-off command during either wait phase aborts that phase.

All delays are counted in pulses of a free-running 1 ms tick input. Parameters give the base lengths: `PV_BASE` ticks is the shortest power-valid delay, and `RST_SHORT` and `RST_LONG` are the two reset-release delays. The defaults are 16, 20 and 100.

Top module: `hp_slot_pwr_seq`

## Requirements
- R1: After reset, slot_pwr_en, pwr_valid, msg_req and seq_done are 0 and slot_rst_n is 0.
- R2: The present signal is prsnt_pin when cfg_prs_sel=0 and rx_detect when cfg_prs_sel=1. The unselected input has no effect. cmd_on is ignored unless the block is powered off and present is 1.
- R3: slot_pwr_en rises on the clock edge that samples an accepted cmd_on. pwr_valid rises on the edge that samples the Nth tick after that, where N = PV_BASE times 1, 2, 4 or 8 for cfg_pv_dly = 00, 01, 10 or 11.
- R4: slot_rst_n rises on the edge that samples the Mth tick after pwr_valid rose. M = RST_SHORT when cfg_rst_long=0 and RST_LONG when cfg_rst_long=1.
- R5: slot_rst_n is 1 only in the running state, where slot_pwr_en and pwr_valid are both 1. pwr_valid is never 1 without slot_pwr_en.
- R6: With cfg_msg_en=1, cmd_off in the running state sets msg_req, asserts reset and keeps power and power-valid on until msg_ack. On the edge that samples msg_ack, power and msg_req drop.
- R7: If no msg_ack arrives, power drops on the edge that samples the Nth tick after msg_req rose, with N as in R3.
- R8: With cfg_msg_en=0, cmd_off in the running state drops slot_pwr_en on the next edge.
- R9: If present falls in any powered state, power drops on the next edge and msg_req is never raised.
- R10: cmd_off during the power-valid wait or the reset-release wait drops slot_pwr_en on the next edge.
- R11: seq_done is a one-cycle pulse. It is set together with the rise of slot_rst_n, and again one cycle after power drops, when the block returns to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per millisecond |
| cfg_pv_dly | input | 2 | Power-valid delay select |
| cfg_rst_long | input | 1 | Reset-release delay select (1 = long) |
| cfg_prs_sel | input | 1 | Presence source: 0 pin, 1 receiver detect |
| cfg_msg_en | input | 1 | Turn-off message handshake enable |
| prsnt_pin | input | 1 | Presence pin, 1 = card present |
| rx_detect | input | 1 | Receiver-detect result, 1 = card present |
| cmd_on | input | 1 | Power-on command pulse |
| cmd_off | input | 1 | Power-off command pulse |
| msg_ack | input | 1 | Turn-off message handed off |
| slot_pwr_en | output | 1 | Slot power enable |
| pwr_valid | output | 1 | Slot power valid status |
| slot_rst_n | output | 1 | Slot reset, active low |
| msg_req | output | 1 | Turn-off message request |
| seq_done | output | 1 | Sequence completed pulse |

## Verification
The bench builds the block with PV_BASE=2, RST_SHORT=3 and RST_LONG=5. With these values, every delay code and the message watchdog complete within a few dozen tick pulses. This lets the bench count exact tick numbers for all four power-valid settings and both reset-release settings. It also covers aborts, removals and the acknowledge and watchdog exits, with each phase hit on its exact boundary tick.

// File: rtl/hp_slot_pwr_seq.sv
module hp_slot_pwr_seq #(
  parameter int PV_BASE   = 16,
  parameter int RST_SHORT = 20,
  parameter int RST_LONG  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cfg_pv_dly,
  input  logic       cfg_rst_long,
  input  logic       cfg_prs_sel,
  input  logic       cfg_msg_en,
  input  logic       prsnt_pin,
  input  logic       rx_detect,
  input  logic       cmd_on,
  input  logic       cmd_off,
  input  logic       msg_ack,
  output logic       slot_pwr_en,
  output logic       pwr_valid,
  output logic       slot_rst_n,
  output logic       msg_req,
  output logic       seq_done
);
  localparam int PV_MAX = PV_BASE * 8;
  localparam int RST_MAX = (RST_LONG > RST_SHORT) ? RST_LONG : RST_SHORT;
  localparam int LIM_MAX = (PV_MAX > RST_MAX) ? PV_MAX : RST_MAX;
  localparam int CW = $clog2(LIM_MAX + 1);

  typedef enum logic [2:0] {
    S_OFF, S_PA_WAIT, S_PV_WAIT, S_ACTIVE, S_MSG_WAIT, S_PDOWN
  } seq_t;

  seq_t st, nxt;
  logic [CW-1:0] cnt, cnt_inc, pv_lim, rst_lim, lim;
  logic present, hit;

  assign present = cfg_prs_sel ? rx_detect : prsnt_pin;
  assign pv_lim  = CW'(PV_BASE) << cfg_pv_dly;
  assign rst_lim = cfg_rst_long ? CW'(RST_LONG) : CW'(RST_SHORT);
  assign lim     = (st == S_PV_WAIT) ? rst_lim : pv_lim;
  assign cnt_inc = cnt + CW'(1);
  assign hit     = tick && (cnt_inc == lim);

  always_comb begin
    nxt = st;
    unique case (st)
      S_OFF:      if (cmd_on && present) nxt = S_PA_WAIT;
      S_PA_WAIT:  if (!present || cmd_off) nxt = S_PDOWN;
                  else if (hit) nxt = S_PV_WAIT;
      S_PV_WAIT:  if (!present || cmd_off) nxt = S_PDOWN;
                  else if (hit) nxt = S_ACTIVE;
      S_ACTIVE:   if (!present) nxt = S_PDOWN;
                  else if (cmd_off) nxt = cfg_msg_en ? S_MSG_WAIT : S_PDOWN;
      S_MSG_WAIT: if (!present || msg_ack || hit) nxt = S_PDOWN;
      S_PDOWN:    nxt = S_OFF;
      default:    nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_OFF;
      cnt         <= '0;
      slot_pwr_en <= 1'b0;
      pwr_valid   <= 1'b0;
      slot_rst_n  <= 1'b0;
      msg_req     <= 1'b0;
      seq_done    <= 1'b0;
    end else begin
      st          <= nxt;
      cnt         <= (nxt != st) ? '0 : (tick ? cnt_inc : cnt);
      slot_pwr_en <= nxt inside {S_PA_WAIT, S_PV_WAIT, S_ACTIVE, S_MSG_WAIT};
      pwr_valid   <= nxt inside {S_PV_WAIT, S_ACTIVE, S_MSG_WAIT};
      slot_rst_n  <= (nxt == S_ACTIVE);
      msg_req     <= (nxt == S_MSG_WAIT);
      seq_done    <= (nxt == S_ACTIVE && st != S_ACTIVE) ||
                     (nxt == S_OFF && st == S_PDOWN);
    end
  end
endmodule

// File: rtl/hp_slot_pwr_seq_chk.sv
module hp_slot_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_prs_sel,
  input logic prsnt_pin,
  input logic rx_detect,
  input logic slot_pwr_en,
  input logic pwr_valid,
  input logic slot_rst_n,
  input logic msg_req,
  input logic seq_done
);
  logic present;
  assign present = cfg_prs_sel ? rx_detect : prsnt_pin;

  assert_rst_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst_n |-> (slot_pwr_en && pwr_valid && !msg_req));
  assert_valid_needs_pwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |-> slot_pwr_en);
  assert_msg_holds_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (slot_pwr_en && pwr_valid && !slot_rst_n));
  assert_removal_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pwr_en && !present) |=> (!slot_pwr_en && !msg_req));
  assert_on_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_pwr_en && !present) |=> !slot_pwr_en);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
endmodule

bind hp_slot_pwr_seq hp_slot_pwr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_prs_sel(cfg_prs_sel), .prsnt_pin(prsnt_pin),
  .rx_detect(rx_detect), .slot_pwr_en(slot_pwr_en), .pwr_valid(pwr_valid),
  .slot_rst_n(slot_rst_n), .msg_req(msg_req), .seq_done(seq_done)
);

// File: tb/hp_slot_pwr_seq_tb_top.sv
module hp_slot_pwr_seq_tb_top;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] cfg_pv_dly = 0;
  logic cfg_rst_long = 0, cfg_prs_sel = 0, cfg_msg_en = 0;
  logic prsnt_pin = 1, rx_detect = 1, cmd_on = 0, cmd_off = 0, msg_ack = 0;
  logic slot_pwr_en, pwr_valid, slot_rst_n, msg_req, seq_done;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  hp_slot_pwr_seq #(.PV_BASE(2), .RST_SHORT(3), .RST_LONG(5)) dut_i (
    .clk, .rst_n, .tick, .cfg_pv_dly, .cfg_rst_long, .cfg_prs_sel, .cfg_msg_en,
    .prsnt_pin, .rx_detect, .cmd_on, .cmd_off, .msg_ack,
    .slot_pwr_en, .pwr_valid, .slot_rst_n, .msg_req, .seq_done);

  // {pv_dly[1:0], rst_long, prs_sel, exp_pv_ticks[5:0], exp_rst_ticks[5:0]}
  localparam logic [15:0] VEC [5] = '{
    {2'b00, 1'b0, 1'b0, 6'd2,  6'd3},
    {2'b01, 1'b1, 1'b1, 6'd4,  6'd5},
    {2'b10, 1'b0, 1'b1, 6'd8,  6'd3},
    {2'b11, 1'b1, 1'b0, 6'd16, 6'd5},
    {2'b00, 1'b1, 1'b0, 6'd2,  6'd5}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0; @(negedge clk);
  endtask

  task automatic pulse_on();
    cmd_on = 1; @(negedge clk); cmd_on = 0;
  endtask

  task automatic pulse_off();
    cmd_off = 1; @(negedge clk); cmd_off = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) pulse_tick();
  endtask

  task automatic settle_off();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 pwr_en", slot_pwr_en, 0);
    check("R1 valid", pwr_valid, 0);
    check("R1 rst_n", slot_rst_n, 0);
    check("R1 msg_req", msg_req, 0);
    check("R1 done", seq_done, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[v]) begin
      int n;
      {cfg_pv_dly, cfg_rst_long, cfg_prs_sel} = VEC[v][15:12];
      pulse_on();
      check("R3 pwr_en after on", slot_pwr_en, 1);
      check("R3 valid low at entry", pwr_valid, 0);
      n = 0;
      while (!pwr_valid && n < 40) begin pulse_tick(); n++; end
      check("R3 pv ticks", n, int'(VEC[v][11:6]));
      check("R5 rst held in pv wait", slot_rst_n, 0);
      n = 0;
      while (!slot_rst_n && n < 40) begin pulse_tick(); n++; end
      check("R4 rst ticks", n, int'(VEC[v][5:0]));
      n = 0;
      while (!slot_rst_n && n < 40) n++;
      pulse_off();
      check("R8 power drop", slot_pwr_en, 0);
      check("R5 rst low off", slot_rst_n, 0);
      @(negedge clk);
      check("R11 done on off", seq_done, 1);
      @(negedge clk);
      check("R11 done one cycle", seq_done, 0);
    end

    // R11 done pulse on reaching active
    cfg_pv_dly = 0; cfg_rst_long = 0; cfg_prs_sel = 0;
    pulse_on(); ticks(2); ticks(2);
    check("R11 no done before active", seq_done, 0);
    tick = 1; @(negedge clk); tick = 0;
    check("R11 done at active", seq_done, 1);
    check("R4 rst released", slot_rst_n, 1);
    @(negedge clk);
    check("R11 done cleared", seq_done, 0);
    pulse_on();
    check("R2 on ignored while active", slot_rst_n, 1);
    pulse_off(); settle_off();

    // R2 presence select
    cfg_prs_sel = 0; prsnt_pin = 0; rx_detect = 1;
    pulse_on(); @(negedge clk);
    check("R2 pin absent ignores on", slot_pwr_en, 0);
    cfg_prs_sel = 1;
    pulse_on();
    check("R2 rx present accepts on", slot_pwr_en, 1);
    @(negedge clk);
    check("R2 pin ignored when rx selected", slot_pwr_en, 1);
    // R10 abort in power-valid wait
    pulse_off();
    check("R10 abort pa wait", slot_pwr_en, 0);
    settle_off();
    pulse_on(); ticks(2);
    check("R10 in rst wait", pwr_valid, 1);
    pulse_off();
    check("R10 abort rst wait", slot_pwr_en, 0);
    settle_off();

    // R6 message with acknowledge
    cfg_msg_en = 1;
    pulse_on(); ticks(5);
    check("R6 active", slot_rst_n, 1);
    pulse_off();
    check("R6 msg_req", msg_req, 1);
    check("R6 rst asserted", slot_rst_n, 0);
    repeat (3) @(negedge clk);
    check("R6 power held", slot_pwr_en, 1);
    check("R6 valid held", pwr_valid, 1);
    msg_ack = 1; @(negedge clk); msg_ack = 0;
    check("R6 power drop on ack", slot_pwr_en, 0);
    check("R6 req drop", msg_req, 0);
    settle_off();

    // R7 watchdog
    pulse_on(); ticks(5);
    pulse_off();
    pulse_tick();
    check("R7 still waiting", msg_req, 1);
    tick = 1; @(negedge clk); tick = 0;
    check("R7 watchdog drop", slot_pwr_en, 0);
    settle_off();

    // R9 removal in active skips message
    pulse_on(); ticks(5);
    rx_detect = 0; @(negedge clk);
    check("R9 removal drop", slot_pwr_en, 0);
    check("R9 no msg", msg_req, 0);
    settle_off();
    rx_detect = 1;
    pulse_on(); ticks(1);
    rx_detect = 0; @(negedge clk);
    check("R9 removal in wait", slot_pwr_en, 0);
    settle_off();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule